// File: doc/BRIEF.md
# ATA Device Task-File Register Controller

This block is the register front end that a storage device presents to its host over a parallel ATA-style bus. The host selects either the command block (eight byte-wide registers) or the control block (two registers) and reads or writes one byte per strobe. The block holds the task-file registers and forms a 28-bit logical block address from them. It runs the command handshake through the busy flag and tracks a three-level power state. It also records interface CRC errors reported by the transfer engine.

Two reset paths exist. The synchronous `rst` input is the hard reset. After a hard reset the block holds busy for a fixed window. During that window a master device watches the peer-presence line and then samples the peer's diagnostic result. A soft reset is started through a bit in the device-control register. It restores the task file and wakes the device, but it leaves the peer handshake results untouched. Media access, data transfer and CRC generation live outside the block.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After hard reset is released, status bit 7 (busy) stays high for exactly HS_CYCLES clocks and bit 6 (ready) is low. Status then reads 40h, with sector count 01h, sector number 01h, both cylinder bytes 00h, drive/head 00h, error 00h and power state active (code 0).
- R2: Command-block offsets 0 and 2 to 6 (data, sector count, sector number, cylinder low, cylinder high, drive/head) read back the byte last written. A write at offset 1 does not change the error register, which reads at offset 1.
- R3: The output `lba` equals {drive/head[3:0], cylinder high, cylinder low, sector number}, and `lba_mode` equals drive/head bit 6.
- R4: A command write (offset 7) with busy low holds busy high for exactly CMD_CYCLES clocks. Ready stays high throughout.
- R5: While busy is high, command-block writes leave every register unchanged, and a read at any address returns the status byte.
- R6: A command code other than E5h, E1h or E6h sets error bit 2 (abort), and status bit 0 then reads 1. Any accepted command clears the error register first.
- R7: A one-cycle pulse on `xfer_crc_err` sets error bit 7, which stays set until the next accepted command clears it.
- R8: Command E5h (power query) loads sector count with 00h if the device was asleep and with FFh if it was active or idle. No other value, and never 80h, is produced.
- R9: E1h moves the power state to idle (code 1) and E6h to sleep (code 2). Every other command, including unsupported ones, moves a sleeping device to active and leaves an active or idle device unchanged.
- R10: Writing control offset 6 with bit 2 set holds busy high with ready low, keeps the task file at its reset values and forces the power state to active. Clearing the bit drops busy on the next clock. Peer handshake results are left unchanged.
- R11: In the hard-reset window, a master sets `peer_found` if `peer_present` is high in any window cycle. At the window's end it sets `peer_passed` = found AND `peer_diag_pass`. A non-master reports 0 for both.
- R12: Control offset 7 reads {1, 1, ~drive/head[3:0], ~drive/head[4], drive/head[4]}, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| dev_is_master | input | 1 | Device is bus master (runs the peer handshake) |
| host_ctl_sel | input | 1 | 1 selects the control block, 0 the command block |
| host_addr | input | 3 | Register offset within the selected block |
| host_wr | input | 1 | Write strobe, one clock per byte |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of `host_rd`, 0 otherwise |
| xfer_crc_err | input | 1 | Pulse from the transfer engine on a data-phase CRC error |
| peer_present | input | 1 | Peer-presence line, high means present |
| peer_diag_pass | input | 1 | Peer diagnostic line, high means passed |
| bsy | output | 1 | Busy flag as seen in status bit 7 |
| pwr_state | output | 2 | 0 active, 1 idle, 2 sleep |
| lba | output | 28 | Assembled logical block address |
| lba_mode | output | 1 | Drive/head bit 6 |
| peer_found | output | 1 | Peer seen during the last hard-reset window |
| peer_passed | output | 1 | Peer present and diagnostics passed |

## Verification
The hardest state to reach is a register access that lands while a command is still in flight. The bench issues a command and, in the cycles that follow before busy falls, writes a task-file register and reads a different one. It then checks that the write was dropped and that the read returned the busy status. The query response from sleep is also hard to reach, because any command wakes the device. The bench therefore sends the sleep command and the query back to back, so the response is computed from the state held when the query was accepted. The peer handshake is exercised by pulsing presence for a single cycle in the middle of the window, and by repeating hard resets with the master input and the diagnostic line varied.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_IDLE   = 2'd1,
        PWR_SLEEP  = 2'd2
    } pwr_e;

    typedef enum logic [2:0] {
        TF_DATA    = 3'd0,
        TF_ERRFEAT = 3'd1,
        TF_COUNT   = 3'd2,
        TF_SECNUM  = 3'd3,
        TF_CYLLO   = 3'd4,
        TF_CYLHI   = 3'd5,
        TF_HEAD    = 3'd6,
        TF_STATCMD = 3'd7
    } tf_off_e;

    localparam logic [2:0] CTL_ALTSTAT = 3'd6;
    localparam logic [2:0] CTL_DRVADDR = 3'd7;

    localparam logic [7:0] OP_QUERY_PWR = 8'hE5;
    localparam logic [7:0] OP_GO_IDLE   = 8'hE1;
    localparam logic [7:0] OP_GO_SLEEP  = 8'hE6;
    localparam logic [7:0] RESP_AWAKE   = 8'hFF;
    localparam logic [7:0] RESP_ASLEEP  = 8'h00;

    localparam int ST_BSY    = 7;
    localparam int ST_DRDY   = 6;
    localparam int ST_ERR    = 0;
    localparam int ERR_CRC   = 7;
    localparam int ERR_ABRT  = 2;
    localparam int DCTL_SRST = 2;
    localparam int HEAD_LBA  = 6;
    localparam int HEAD_DEV  = 4;

    typedef struct packed {
        logic [7:0] data;
        logic [7:0] err;
        logic [7:0] count;
        logic [7:0] secnum;
        logic [7:0] cyllo;
        logic [7:0] cylhi;
        logic [7:0] head;
    } tf_regs_t;

    typedef struct packed {
        logic       done;
        logic       abort;
        logic       cnt_we;
        logic [7:0] cnt_val;
    } cmd_result_t;

    function automatic tf_regs_t tf_defaults();
        tf_regs_t r;
        r.data   = 8'h00;
        r.err    = 8'h00;
        r.count  = 8'h01;
        r.secnum = 8'h01;
        r.cyllo  = 8'h00;
        r.cylhi  = 8'h00;
        r.head   = 8'h00;
        return r;
    endfunction

    function automatic logic [27:0] lba_of(tf_regs_t r);
        return {r.head[3:0], r.cylhi, r.cyllo, r.secnum};
    endfunction

    function automatic logic op_supported(logic [7:0] op);
        return (op == OP_QUERY_PWR) || (op == OP_GO_IDLE) || (op == OP_GO_SLEEP);
    endfunction

    function automatic logic [7:0] drive_addr_of(logic [7:0] head);
        return {2'b11, ~head[3:0], ~head[HEAD_DEV], head[HEAD_DEV]};
    endfunction

endpackage

// File: rtl/tfc_hs_seq.sv
module tfc_hs_seq
    import tfc_pkg::*;
#(
    parameter int HS_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic is_master,
    input  logic peer_here,
    input  logic peer_ok,
    output logic window,
    output logic found,
    output logic passed
);
    localparam int CW = (HS_CYCLES > 1) ? $clog2(HS_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            window <= 1'b1;
            cnt_q  <= CW'(HS_CYCLES - 1);
            found  <= 1'b0;
            passed <= 1'b0;
        end else if (window) begin
            if (is_master && peer_here) begin
                found <= 1'b1;
            end
            if (cnt_q == '0) begin
                window <= 1'b0;
                passed <= is_master && (found || peer_here) && peer_ok;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R11: handshake results only move inside the window
    p_frozen_after_window_r11: assert property (@(posedge clk) disable iff (rst)
        !window |=> ($stable(found) && $stable(passed)));

    // R11: a pass verdict implies the peer was seen
    p_pass_needs_found_r11: assert property (@(posedge clk) disable iff (rst)
        passed |-> found);

endmodule

// File: rtl/tfc_cmd_seq.sv
module tfc_cmd_seq
    import tfc_pkg::*;
#(
    parameter int CMD_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_code,
    output logic        busy,
    output pwr_e        pwr,
    output cmd_result_t res
);
    localparam int CW = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic [7:0]    op_q;
    logic          finish;
    pwr_e          pwr_next;

    always_comb begin
        finish      = busy && (cnt_q == '0) && !hold;
        res.done    = finish;
        res.abort   = finish && !op_supported(op_q);
        res.cnt_we  = finish && (op_q == OP_QUERY_PWR);
        res.cnt_val = (pwr == PWR_SLEEP) ? RESP_ASLEEP : RESP_AWAKE;
        if (op_q == OP_GO_IDLE) begin
            pwr_next = PWR_IDLE;
        end else if (op_q == OP_GO_SLEEP) begin
            pwr_next = PWR_SLEEP;
        end else if (pwr == PWR_SLEEP) begin
            pwr_next = PWR_ACTIVE;
        end else begin
            pwr_next = pwr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op_q  <= '0;
            pwr   <= PWR_ACTIVE;
        end else if (hold) begin
            busy <= 1'b0;
            pwr  <= PWR_ACTIVE;
        end else if (cmd_wr) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CMD_CYCLES - 1);
            op_q  <= cmd_code;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
                pwr  <= pwr_next;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: busy only rises after an accepted command write
    p_busy_from_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr));

    // R9: the power state changes only at command completion or soft reset
    p_pwr_moves_on_finish_r9: assert property (@(posedge clk) disable iff (rst)
        (!finish && !hold) |=> $stable(pwr));

    // R10: soft reset cancels a command in flight
    p_hold_cancels_r10: assert property (@(posedge clk) disable iff (rst)
        hold |=> !busy);

endmodule

// File: rtl/tfc_regfile.sv
module tfc_regfile
    import tfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        cmd_start,
    input  logic        crc_evt,
    input  cmd_result_t res,
    output tf_regs_t    regs
);
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            regs <= tf_defaults();
        end else begin
            if (wr_en) begin
                case (tf_off_e'(addr))
                    TF_DATA:   regs.data   <= wdata;
                    TF_COUNT:  regs.count  <= wdata;
                    TF_SECNUM: regs.secnum <= wdata;
                    TF_CYLLO:  regs.cyllo  <= wdata;
                    TF_CYLHI:  regs.cylhi  <= wdata;
                    TF_HEAD:   regs.head   <= wdata;
                    default: ;
                endcase
            end
            if (cmd_start) begin
                regs.err <= 8'h00;
            end
            if (res.done && res.abort) begin
                regs.err[ERR_ABRT] <= 1'b1;
            end
            if (res.cnt_we) begin
                regs.count <= res.cnt_val;
            end
            if (crc_evt) begin
                regs.err[ERR_CRC] <= 1'b1;
            end
        end
    end

    // R8: the query response is only ever the awake or asleep code
    p_query_codes_r8: assert property (@(posedge clk) disable iff (rst)
        res.cnt_we |-> ((res.cnt_val == RESP_AWAKE) || (res.cnt_val == RESP_ASLEEP)));

    // R7: a reported CRC error is recorded
    p_crc_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (crc_evt && !hold) |=> regs.err[ERR_CRC]);

    // R6: an accepted command starts with a clean error register
    p_err_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !crc_evt && !hold) |=> (regs.err == 8'h00));

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import tfc_pkg::*;
#(
    parameter int CMD_CYCLES = 6,
    parameter int HS_CYCLES  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dev_is_master,
    input  logic        host_ctl_sel,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        xfer_crc_err,
    input  logic        peer_present,
    input  logic        peer_diag_pass,
    output logic        bsy,
    output logic [1:0]  pwr_state,
    output logic [27:0] lba,
    output logic        lba_mode,
    output logic        peer_found,
    output logic        peer_passed
);
    logic        srst_q;
    logic        hs_window;
    logic        cmd_busy;
    logic        drdy;
    logic        cmdblk_wr;
    logic        cmd_wr;
    logic [7:0]  status;
    pwr_e        pwr;
    cmd_result_t res;
    tf_regs_t    regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q <= 1'b0;
        end else if (host_wr && host_ctl_sel && (host_addr == CTL_ALTSTAT)) begin
            srst_q <= host_wdata[DCTL_SRST];
        end
    end

    always_comb begin
        bsy       = hs_window || srst_q || cmd_busy;
        drdy      = !hs_window && !srst_q;
        cmdblk_wr = host_wr && !host_ctl_sel && !bsy;
        cmd_wr    = cmdblk_wr && (tf_off_e'(host_addr) == TF_STATCMD);
        status           = 8'h00;
        status[ST_BSY]   = bsy;
        status[ST_DRDY]  = drdy;
        status[ST_ERR]   = |regs.err;
    end

    tfc_hs_seq #(.HS_CYCLES(HS_CYCLES)) u_hs (
        .clk       (clk),
        .rst       (rst),
        .is_master (dev_is_master),
        .peer_here (peer_present),
        .peer_ok   (peer_diag_pass),
        .window    (hs_window),
        .found     (peer_found),
        .passed    (peer_passed)
    );

    tfc_cmd_seq #(.CMD_CYCLES(CMD_CYCLES)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .hold     (srst_q),
        .cmd_wr   (cmd_wr),
        .cmd_code (host_wdata),
        .busy     (cmd_busy),
        .pwr      (pwr),
        .res      (res)
    );

    tfc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .hold      (srst_q),
        .wr_en     (cmdblk_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cmd_start (cmd_wr),
        .crc_evt   (xfer_crc_err),
        .res       (res),
        .regs      (regs)
    );

    always_comb begin
        host_rdata = 8'h00;
        if (host_rd) begin
            if (bsy) begin
                host_rdata = status;
            end else if (host_ctl_sel) begin
                if (host_addr == CTL_ALTSTAT) begin
                    host_rdata = status;
                end else if (host_addr == CTL_DRVADDR) begin
                    host_rdata = drive_addr_of(regs.head);
                end
            end else begin
                case (tf_off_e'(host_addr))
                    TF_DATA:    host_rdata = regs.data;
                    TF_ERRFEAT: host_rdata = regs.err;
                    TF_COUNT:   host_rdata = regs.count;
                    TF_SECNUM:  host_rdata = regs.secnum;
                    TF_CYLLO:   host_rdata = regs.cyllo;
                    TF_CYLHI:   host_rdata = regs.cylhi;
                    TF_HEAD:    host_rdata = regs.head;
                    default:    host_rdata = status;
                endcase
            end
        end
    end

    assign pwr_state = pwr;
    assign lba       = lba_of(regs);
    assign lba_mode  = regs.head[HEAD_LBA];

    // R5: command-block writes during busy leave the task file untouched
    p_busy_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (bsy && host_wr && !host_ctl_sel && !srst_q)
            |=> ($stable(regs.secnum) && $stable(regs.head) && $stable(regs.data)));

    // R10: a held soft reset forces the active power state
    p_srst_wakes_r10: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (pwr_state == PWR_ACTIVE));

    // R1: ready is never reported while the hard-reset window is open
    p_no_ready_in_window_r1: assert property (@(posedge clk) disable iff (rst)
        hs_window |-> (bsy && !status[ST_DRDY]));

endmodule

// File: tb/tb_ata_taskfile_ctrl.sv
`timescale 1ns/1ps
module tb_ata_taskfile_ctrl;
    localparam int CMDC = 6;
    localparam int HSC  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_is_master = 1'b1;
    logic        host_ctl_sel = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        xfer_crc_err = 1'b0;
    logic        peer_present = 1'b0;
    logic        peer_diag_pass = 1'b0;
    logic        bsy;
    logic [1:0]  pwr_state;
    logic [27:0] lba;
    logic        lba_mode;
    logic        peer_found;
    logic        peer_passed;

    int checks = 0;
    int errs   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    ata_taskfile_ctrl #(.CMD_CYCLES(CMDC), .HS_CYCLES(HSC)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare every read against the scoreboard
    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "monitor: read without expectation", {24'h0, host_rdata}, 32'h0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(host_rdata == e, t, {24'h0, host_rdata}, {24'h0, e});
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic ctl, input logic [2:0] a, input logic [7:0] d);
        host_ctl_sel = ctl; host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic ctl, input logic [2:0] a, input logic [7:0] e, input string t);
        host_ctl_sel = ctl; host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        step();
        host_rd = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (bsy && n < 1000) begin
            step();
            n++;
        end
    endtask

    task automatic cmd(input logic [7:0] op, input string t);
        int n;
        wr(1'b0, 3'd7, op);
        busy_len(n);
        chk(n == CMDC, {"R4 busy length ", t}, n, CMDC);
    endtask

    task automatic hard_reset(input logic master, input logic pulse, input logic diag);
        int n;
        dev_is_master = master; peer_diag_pass = diag; peer_present = 1'b0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        n = 0;
        while (bsy && n < 1000) begin
            peer_present = pulse && (n == 3);
            step();
            n++;
        end
        peer_present = 1'b0;
        chk(n == HSC, "R1 hard-reset busy window", n, HSC);
    endtask

    initial begin
        #800000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        step(); step();
        hard_reset(1'b1, 1'b1, 1'b1);
        chk(peer_found == 1'b1, "R11 master sees peer", peer_found, 1);
        chk(peer_passed == 1'b1, "R11 peer passed", peer_passed, 1);
        chk(pwr_state == 2'd0, "R1 power active", pwr_state, 0);
        rd(1'b1, 3'd6, 8'h40, "R1 status ready");
        rd(1'b0, 3'd2, 8'h01, "R1 count default");
        rd(1'b0, 3'd3, 8'h01, "R1 secnum default");
        rd(1'b0, 3'd4, 8'h00, "R1 cyllo default");
        rd(1'b0, 3'd5, 8'h00, "R1 cylhi default");
        rd(1'b0, 3'd6, 8'h00, "R1 head default");
        rd(1'b0, 3'd1, 8'h00, "R1 error default");

        // R2 register decode
        wr(1'b0, 3'd2, 8'h12); wr(1'b0, 3'd3, 8'h34); wr(1'b0, 3'd4, 8'h56);
        wr(1'b0, 3'd5, 8'h78); wr(1'b0, 3'd6, 8'h4A); wr(1'b0, 3'd0, 8'h9C);
        wr(1'b0, 3'd1, 8'hFF);
        rd(1'b0, 3'd2, 8'h12, "R2 count");
        rd(1'b0, 3'd3, 8'h34, "R2 secnum");
        rd(1'b0, 3'd4, 8'h56, "R2 cyllo");
        rd(1'b0, 3'd5, 8'h78, "R2 cylhi");
        rd(1'b0, 3'd6, 8'h4A, "R2 head");
        rd(1'b0, 3'd0, 8'h9C, "R2 data");
        rd(1'b0, 3'd1, 8'h00, "R2 feature write leaves error");

        // R3 address assembly
        chk(lba == 28'hA785634, "R3 lba", lba, 28'hA785634);
        chk(lba_mode == 1'b1, "R3 lba mode on", lba_mode, 1);
        wr(1'b0, 3'd6, 8'h0A);
        chk(lba_mode == 1'b0, "R3 lba mode off", lba_mode, 0);
        wr(1'b0, 3'd6, 8'h5B);
        chk(lba == 28'hB785634, "R3 lba high nibble", lba, 28'hB785634);

        // R12 drive address
        rd(1'b1, 3'd7, 8'hD1, "R12 drive address");
        wr(1'b1, 3'd7, 8'h04);
        chk(bsy == 1'b0, "R12 write to drive address no effect", bsy, 0);
        rd(1'b1, 3'd7, 8'hD1, "R12 drive address after write");

        // R4/R8 query from active
        cmd(8'hE5, "query active");
        rd(1'b0, 3'd2, 8'hFF, "R8 query active gives FF");
        rd(1'b1, 3'd6, 8'h40, "R6 supported command no error");

        // R5 access while busy
        begin
            int n;
            wr(1'b0, 3'd7, 8'hE1);
            wr(1'b0, 3'd3, 8'h77);
            rd(1'b0, 3'd2, 8'hC0, "R5 read during busy gives status");
            busy_len(n);
            chk(n == CMDC - 2, "R4 busy remaining", n, CMDC - 2);
        end
        rd(1'b0, 3'd3, 8'h34, "R5 busy write dropped");
        chk(pwr_state == 2'd1, "R9 idle", pwr_state, 1);
        cmd(8'hE5, "query idle");
        rd(1'b0, 3'd2, 8'hFF, "R8 query idle gives FF");
        chk(pwr_state == 2'd1, "R9 query keeps idle", pwr_state, 1);

        // R8/R9 sleep
        cmd(8'hE6, "sleep");
        chk(pwr_state == 2'd2, "R9 sleep", pwr_state, 2);
        cmd(8'hE5, "query sleep");
        rd(1'b0, 3'd2, 8'h00, "R8 query asleep gives 00");
        chk(pwr_state == 2'd0, "R9 query wakes", pwr_state, 0);

        // R6 abort, also wakes
        cmd(8'hE6, "sleep again");
        cmd(8'h42, "unsupported");
        chk(pwr_state == 2'd0, "R9 unsupported wakes", pwr_state, 0);
        rd(1'b0, 3'd1, 8'h04, "R6 abort bit");
        rd(1'b0, 3'd7, 8'h41, "R6 status error bit");
        cmd(8'hE5, "clear");
        rd(1'b0, 3'd1, 8'h00, "R6 error cleared");

        // R7 CRC flag
        xfer_crc_err = 1'b1; step(); xfer_crc_err = 1'b0;
        step(); step();
        rd(1'b0, 3'd1, 8'h80, "R7 crc flag");
        rd(1'b1, 3'd6, 8'h41, "R7 status error bit");
        cmd(8'hE1, "after crc");
        rd(1'b0, 3'd1, 8'h00, "R7 crc cleared by command");

        // R10 soft reset
        cmd(8'hE6, "sleep before srst");
        wr(1'b0, 3'd3, 8'h99);
        wr(1'b1, 3'd6, 8'h04);
        chk(bsy == 1'b1, "R10 srst busy", bsy, 1);
        step();
        chk(pwr_state == 2'd0, "R10 srst wakes", pwr_state, 0);
        rd(1'b0, 3'd2, 8'h80, "R10 status during srst");
        wr(1'b1, 3'd6, 8'h00);
        chk(bsy == 1'b0, "R10 busy drops", bsy, 0);
        rd(1'b0, 3'd3, 8'h01, "R10 secnum restored");
        rd(1'b0, 3'd2, 8'h01, "R10 count restored");
        rd(1'b1, 3'd6, 8'h40, "R10 ready after srst");
        chk(peer_found == 1'b1, "R10 handshake untouched", peer_found, 1);

        // R11 handshake variants
        hard_reset(1'b1, 1'b0, 1'b1);
        chk(peer_found == 1'b0, "R11 no peer found", peer_found, 0);
        chk(peer_passed == 1'b0, "R11 no peer passed", peer_passed, 0);
        hard_reset(1'b0, 1'b1, 1'b1);
        chk(peer_found == 1'b0, "R11 non-master found", peer_found, 0);
        chk(peer_passed == 1'b0, "R11 non-master passed", peer_passed, 0);
        hard_reset(1'b1, 1'b1, 1'b0);
        chk(peer_found == 1'b1, "R11 peer found diag fail", peer_found, 1);
        chk(peer_passed == 1'b0, "R11 diag failed", peer_passed, 0);

        step();
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule